// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave is holding low after it was cut off partway through a byte. A pulse on the request input, given while the block is idle, makes the block take the SCL and SDA drive-low enables away from the functional engine. Both lines are first released for one settle interval. Nine SCL clocks follow, each made of a low interval and then a high interval, with SDA left released so that a slave can shift out whatever remains of its byte. The block then makes a stop condition: SDA is pulled low for one interval while SCL stays released, and both lines are then released for one final interval. After that the engine's own drive-low enables are routed to the pins again, unchanged.

Each interval lasts a set number of pulses of an external timebase tick, about 10 µs of ticks at microsecond scale. During the SCL high intervals a tick counts only while the sampled SCL line reads high, so a slave that stretches the clock lengthens that interval. A busy flag covers the whole sequence. A one-cycle done pulse then tells the controller that it can test for bus-idle again. Deciding that the bus is stuck, and retrying initialisation, are left to the surrounding controller.

Top module: `bus_recovery_seq`

## Requirements
- R1: Out of reset, busy and done are 0. While idle, sclDrvLow equals engSclDrvLow and sdaDrvLow equals engSdaDrvLow. A drive-low enable of 1 pulls the line low and 0 releases it.
- R2: A request sampled high while idle starts the sequence. From the next cycle both drive-low enables are 0 for one interval, whatever the engine inputs are.
- R3: Exactly nine SCL pulses follow. Each pulse is one interval with sclDrvLow=1 and then one interval with sclDrvLow=0, and sdaDrvLow stays 0 for all of them.
- R4: After the ninth high interval, sdaDrvLow=1 with sclDrvLow=0 for one interval. Both enables are then 0 for one interval.
- R5: In the cycle after the last interval ends, the pins again follow the engine inputs.
- R6: busy is 1 from the cycle after the accepted request through the last interval, and it is 0 in the cycle where the engine regains the pins.
- R7: done is high for exactly one cycle, the cycle after the engine regains the pins.
- R8: A request that arrives while busy is ignored. The running sequence keeps its shape and its length.
- R9: An interval is PHASE_TICKS cycles in which tick is high. Cycles without a tick do not advance the sequence.
- R10: During an SCL high interval, a tick counts only when sclIn is 1. A slave holding SCL low lengthens that interval by the cycles it holds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| recoverReq | input | 1 | Request to start a recovery sequence |
| tick | input | 1 | Timebase pulse; intervals are counted in these |
| sclIn | input | 1 | Sampled SCL line level |
| engSclDrvLow | input | 1 | Functional engine SCL drive-low enable |
| engSdaDrvLow | input | 1 | Functional engine SDA drive-low enable |
| sclDrvLow | output | 1 | SCL pin drive-low enable |
| sdaDrvLow | output | 1 | SDA pin drive-low enable |
| busy | output | 1 | Recovery in progress, pins under sequencer control |
| done | output | 1 | One-cycle pulse after the pins are returned |

## Verification
With tick high in every cycle, the pins and busy change one cycle after the edge that samples the request, and each interval then lasts exactly PHASE_TICKS cycles. The bench therefore predicts the pin pair for every cycle index counted from that edge. The engine regains the pins at index 21·PHASE_TICKS, plus any stretch cycles, and done is due one index after that. Inputs are driven and outputs sampled on the falling edge, so each index refers to one settled cycle. With sparse ticks, no fixed cycle can be predicted, so the bench counts the ticks that fall inside busy and the SCL low pulses instead.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_LOW,
    ST_HIGH,
    ST_STOP,
    ST_FREE
  } rcvState_t;

  // strobes from control to datapath; scl/sda are levels (1 = released)
  typedef struct packed {
    logic clrCnt;
    logic cntEn;
    logic clrPulse;
    logic incPulse;
    logic loadPins;
    logic manual;
    logic scl;
    logic sda;
  } rcvStrobe_t;

endpackage

// File: rtl/rcv_datapath.sv
module rcv_datapath
  import rcv_pkg::*;
#(
  parameter int PHASE_TICKS = 10,
  parameter int PULSE_COUNT = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  rcvStrobe_t strb,
  input  logic       engSclDrvLow,
  input  logic       engSdaDrvLow,
  output logic       intervalEnd,
  output logic       lastPulse,
  output logic       sclDrvLow,
  output logic       sdaDrvLow
);

  localparam int CNT_W   = $clog2(PHASE_TICKS + 1);
  localparam int PULSE_W = $clog2(PULSE_COUNT + 1);
  localparam logic [CNT_W-1:0]   CNT_LAST   = CNT_W'(PHASE_TICKS - 1);
  localparam logic [PULSE_W-1:0] PULSE_LAST = PULSE_W'(PULSE_COUNT - 1);

  logic [CNT_W-1:0]   tickCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               manualQ;
  logic               manSclQ;
  logic               manSdaQ;

  // interval tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.clrCnt) begin
      tickCnt <= '0;
    end else if (strb.cntEn && tick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign intervalEnd = strb.cntEn && tick && (tickCnt == CNT_LAST);

  // SCL pulse counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strb.clrPulse) begin
      pulseCnt <= '0;
    end else if (strb.incPulse) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  assign lastPulse = (pulseCnt == PULSE_LAST);

  // manual pin levels and ownership
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      manualQ <= 1'b0;
      manSclQ <= 1'b1;
      manSdaQ <= 1'b1;
    end else if (strb.loadPins) begin
      manualQ <= strb.manual;
      manSclQ <= strb.scl;
      manSdaQ <= strb.sda;
    end
  end

  assign sclDrvLow = manualQ ? !manSclQ : engSclDrvLow;
  assign sdaDrvLow = manualQ ? !manSdaQ : engSdaDrvLow;

  // R9: tick count never passes the interval length
  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= CNT_LAST);

  // R3: pulse count never passes the pulse total
  assert_pulse_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PULSE_LAST);

  // R3: SDA is released whenever SCL is held low by the sequencer
  assert_sda_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    (manualQ && !manSclQ) |-> manSdaQ);

endmodule

// File: rtl/rcv_control.sv
module rcv_control
  import rcv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       recoverReq,
  input  logic       sclIn,
  input  logic       intervalEnd,
  input  logic       lastPulse,
  output rcvStrobe_t strb,
  output logic       busy,
  output logic       done
);

  rcvState_t state;
  rcvState_t nextState;
  logic      handBack;
  logic      donePendQ;
  logic      doneQ;

  always_comb begin
    nextState     = state;
    strb          = '0;
    strb.manual   = 1'b1;
    strb.scl      = 1'b1;
    strb.sda      = 1'b1;
    handBack      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strb.manual = 1'b0;
        if (recoverReq) begin
          nextState     = ST_SETTLE;
          strb.loadPins = 1'b1;
          strb.manual   = 1'b1;
          strb.clrCnt   = 1'b1;
          strb.clrPulse = 1'b1;
        end
      end
      ST_SETTLE: begin
        strb.cntEn = 1'b1;
        if (intervalEnd) begin
          nextState     = ST_LOW;
          strb.clrCnt   = 1'b1;
          strb.loadPins = 1'b1;
          strb.scl      = 1'b0;
        end
      end
      ST_LOW: begin
        strb.cntEn = 1'b1;
        if (intervalEnd) begin
          nextState     = ST_HIGH;
          strb.clrCnt   = 1'b1;
          strb.loadPins = 1'b1;
        end
      end
      ST_HIGH: begin
        strb.cntEn = sclIn;
        if (intervalEnd) begin
          strb.clrCnt   = 1'b1;
          strb.loadPins = 1'b1;
          if (lastPulse) begin
            nextState = ST_STOP;
            strb.sda  = 1'b0;
          end else begin
            nextState     = ST_LOW;
            strb.incPulse = 1'b1;
            strb.scl      = 1'b0;
          end
        end
      end
      ST_STOP: begin
        strb.cntEn = 1'b1;
        strb.sda   = 1'b0;
        if (intervalEnd) begin
          nextState     = ST_FREE;
          strb.clrCnt   = 1'b1;
          strb.loadPins = 1'b1;
          strb.sda      = 1'b1;
        end
      end
      ST_FREE: begin
        strb.cntEn = 1'b1;
        if (intervalEnd) begin
          nextState     = ST_IDLE;
          strb.clrCnt   = 1'b1;
          strb.loadPins = 1'b1;
          strb.manual   = 1'b0;
          handBack      = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePendQ <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      state     <= nextState;
      donePendQ <= handBack;
      doneQ     <= donePendQ;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R8: busy only rises after a request in the previous cycle
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(recoverReq));

  // R7: done comes one cycle after busy has fallen
  assert_done_timing_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy, 2) && !$past(busy)));

  // R7: done lasts a single cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
  import rcv_pkg::*;
#(
  parameter int PHASE_TICKS = 10,
  parameter int PULSE_COUNT = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic recoverReq,
  input  logic tick,
  input  logic sclIn,
  input  logic engSclDrvLow,
  input  logic engSdaDrvLow,
  output logic sclDrvLow,
  output logic sdaDrvLow,
  output logic busy,
  output logic done
);

  rcvStrobe_t strb;
  logic       intervalEnd;
  logic       lastPulse;

  rcv_control uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .recoverReq  (recoverReq),
    .sclIn       (sclIn),
    .intervalEnd (intervalEnd),
    .lastPulse   (lastPulse),
    .strb        (strb),
    .busy        (busy),
    .done        (done)
  );

  rcv_datapath #(
    .PHASE_TICKS (PHASE_TICKS),
    .PULSE_COUNT (PULSE_COUNT)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .strb         (strb),
    .engSclDrvLow (engSclDrvLow),
    .engSdaDrvLow (engSdaDrvLow),
    .intervalEnd  (intervalEnd),
    .lastPulse    (lastPulse),
    .sclDrvLow    (sclDrvLow),
    .sdaDrvLow    (sdaDrvLow)
  );

  // R5: whenever not busy, the engine owns both pins
  assert_passthru_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclDrvLow == engSclDrvLow && sdaDrvLow == engSdaDrvLow));

  // R4: SDA is only pulled low by the sequencer while SCL is released
  assert_stop_shape_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sdaDrvLow) |-> !sclDrvLow);

endmodule

// File: tb/sim_bus_recovery_seq.sv
`timescale 1ns/1ps
module sim_bus_recovery_seq;

  localparam int N     = 3;
  localparam int TOTAL = 21 * N;

  // {engScl, engSda, expScl, expSda}
  localparam logic [3:0] PASS_VEC [4] = '{4'b0000, 4'b0101, 4'b1010, 4'b1111};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic recoverReq = 1'b0;
  logic tick = 1'b0;
  logic sclIn = 1'b1;
  logic engSclDrvLow = 1'b0;
  logic engSdaDrvLow = 1'b0;
  logic sclDrvLow, sdaDrvLow, busy, done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_recovery_seq #(.PHASE_TICKS(N), .PULSE_COUNT(9)) u0 (
    .clk(clk), .rstN(rstN), .recoverReq(recoverReq), .tick(tick), .sclIn(sclIn),
    .engSclDrvLow(engSclDrvLow), .engSdaDrvLow(engSdaDrvLow),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected {sclDrvLow, sdaDrvLow} at phase index j of the sequence
  function automatic logic [1:0] seqPins(input int j);
    int ph = j / N;
    if (ph == 0) return 2'b00;
    if (ph <= 18) return (ph % 2 == 1) ? 2'b10 : 2'b00;
    if (ph == 19) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string phaseReq(input int j);
    int ph = j / N;
    if (ph == 0) return "R2";
    if (ph <= 18) return "R3";
    return "R4";
  endfunction

  // full sequence with a tick every cycle; optional stretch and stray request
  task automatic runSeq(input int stretch, input int ignoreAt);
    tick = 1'b1;
    engSclDrvLow = 1'b1;
    engSdaDrvLow = 1'b1;
    @(negedge clk);
    recoverReq = 1'b1;
    @(negedge clk);
    for (int i = 0; i < TOTAL + stretch + 3; i++) begin
      recoverReq = (i == ignoreAt);
      sclIn = !(stretch > 0 && i >= 2 * N && i < 2 * N + stretch);
      if (i < TOTAL + stretch) begin
        int j;
        string rq;
        if (i < 2 * N) j = i;
        else if (i < 2 * N + stretch) j = 2 * N;
        else j = i - stretch;
        rq = (i >= 2 * N && i < 2 * N + stretch) ? "R10" : phaseReq(j);
        check(rq, $sformatf("pins at index %0d", i), int'({sclDrvLow, sdaDrvLow}), int'(seqPins(j)));
        check("R6", $sformatf("busy at index %0d", i), int'(busy), 1);
      end else if (i == TOTAL + stretch) begin
        check("R5", "pins back to engine", int'({sclDrvLow, sdaDrvLow}), 3);
        check("R6", "busy low at handback", int'(busy), 0);
        check("R7", "done not yet at handback", int'(done), 0);
      end else if (i == TOTAL + stretch + 1) begin
        check(ignoreAt >= 0 ? "R8" : "R7", "done one cycle after handback", int'(done), 1);
      end else begin
        check("R7", "done single cycle", int'(done), 0);
      end
      @(negedge clk);
    end
    recoverReq = 1'b0;
    sclIn = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset state
    engSclDrvLow = 1'b0;
    engSdaDrvLow = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "done in reset", int'(done), 0);
    check("R1", "pins in reset", int'({sclDrvLow, sdaDrvLow}), 1);
    rstN = 1'b1;
    @(negedge clk);

    // idle pass-through vectors
    for (int v = 0; v < 4; v++) begin
      engSclDrvLow = PASS_VEC[v][3];
      engSdaDrvLow = PASS_VEC[v][2];
      #1;
      check("R1", $sformatf("idle pass vector %0d", v), int'({sclDrvLow, sdaDrvLow}), int'(PASS_VEC[v][1:0]));
      @(negedge clk);
    end

    // plain sequence
    runSeq(0, -1);
    // stray request while busy
    runSeq(0, 10);
    // clock stretch in the first high interval
    runSeq(5, -1);

    // sparse ticks: every third cycle
    begin
      int tickBusy = 0;
      int lowPulses = 0;
      int busyCycles = 0;
      logic prevScl = 1'b0;
      engSclDrvLow = 1'b0;
      engSdaDrvLow = 1'b0;
      tick = 1'b0;
      @(negedge clk);
      recoverReq = 1'b1;
      @(negedge clk);
      recoverReq = 1'b0;
      for (int k = 0; k < 1000; k++) begin
        tick = (k % 3 == 0);
        if (busy) busyCycles++;
        if (busy && tick) tickBusy++;
        if (sclDrvLow && !prevScl) lowPulses++;
        prevScl = sclDrvLow;
        if (!busy && k > 0) break;
        @(negedge clk);
      end
      check("R9", "ticks consumed by sequence", tickBusy, TOTAL);
      check("R9", "busy longer than tick count", int'(busyCycles > 2 * TOTAL), 1);
      check("R3", "SCL low pulses", lowPulses, 9);
      tick = 1'b1;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule